// File: doc/BRIEF.md
# Content-Aware Refresh Rate Selector

This block chooses, row by row, whether a memory row needs the fast refresh rate or can live with the slow one. It keeps a small table of known weak cells. Each table entry names a row, the bit position of the weak (victim) cell, and two distances: one to the physically adjacent cell below the victim and one to the adjacent cell above it. The block watches every write to the array. For each row it holds a one-bit verdict: does the content last written to that row put a 1 on a recorded victim with 0 on both of its adjacent cells?

A refresh scheduler asks for a row's class through the request port. One cycle later it gets back a single bit: high rate or low rate. Rows with no table entry are always low rate. A row with an entry is high rate only while its stored data forms the failing arrangement. If the block has not yet seen the row's content since reset or since the table changed for that row, the row is high rate.

A mode input switches to the plain scheme. In that mode every row with a valid entry is high rate, whatever it holds.

Top module: `content_refresh_sel`

## Requirements
- R1: A refresh request for a row that no valid table entry names returns low rate (`ref_high` = 0), whatever has been written to it.
- R2: With `base_mode` = 0, a row with a valid entry is high rate only if its most recent snooped data word has bit `victim` = 1, bit `victim - dist_lo` = 0 and bit `victim + dist_hi` = 0. Bit 0 is the least significant bit of `wr_data`.
- R3: An adjacent position that falls outside the word (below bit 0 or above bit ROW_W-1) places no condition on the match.
- R4: When several valid entries name the same row, the row is high rate if any one of them matches.
- R5: With `base_mode` = 1, every row named by a valid entry is high rate and every other row is low rate.
- R6: After reset, and after a table load, the loaded row is high rate until its next snooped write. This also applies to the row the overwritten entry previously named, if that entry was valid.
- R7: When a load and a write address the same row in the same cycle, the load wins and the row stays in the unseen-content state (high rate).
- R8: A request at a clock edge gives `ref_valid` = 1 and its class on the next edge. That class uses the table and row state from before the edge. With no request, `ref_valid` and `ref_high` are 0.
- R9: Reset empties the table and drives `ref_valid` and `ref_high` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_mode | input | 1 | 1 = classify by table membership only |
| ld_en | input | 1 | Write one table entry |
| ld_idx | input | $clog2(N_ENT) | Entry slot to write |
| ld_valid | input | 1 | Valid bit stored in the slot |
| ld_row | input | $clog2(N_ROWS) | Row named by the entry |
| ld_victim | input | $clog2(ROW_W) | Victim bit position |
| ld_dist_lo | input | $clog2(ROW_W) | Distance from victim down to its lower neighbour |
| ld_dist_hi | input | $clog2(ROW_W) | Distance from victim up to its upper neighbour |
| wr_en | input | 1 | Snooped row write |
| wr_row | input | $clog2(N_ROWS) | Row being written |
| wr_data | input | ROW_W | Data written to the row |
| ref_req | input | 1 | Refresh class request |
| ref_row | input | $clog2(N_ROWS) | Row asked about |
| ref_valid | output | 1 | Answer present (one cycle after request) |
| ref_high | output | 1 | 1 = high rate, 0 = low rate |

## Verification
Every answer is due exactly one clock edge after its request. The answer reflects the table and row state from before that edge, so a write or load in the same cycle as a request takes effect for the next request only. The bench drives all inputs on the falling edge. Before each edge it computes the expected answer from its own model state, and it compares the outputs on the following falling edge. Only after that comparison does it apply that cycle's writes and loads to the model.

// File: rtl/crs_pkg.sv
package crs_pkg;
   typedef enum logic {
      RATE_LOW  = 1'b0,
      RATE_HIGH = 1'b1
   } rate_e;

   function automatic bit is_pow2(int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/crs_entry_table.sv
module crs_entry_table #(
   parameter int N_ROWS = 16,
   parameter int ROW_W  = 32,
   parameter int N_ENT  = 4,
   localparam int ROW_AW = $clog2(N_ROWS),
   localparam int BIT_AW = $clog2(ROW_W),
   localparam int ENT_AW = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ENT_AW-1:0] ld_idx,
   input  logic              ld_valid,
   input  logic [ROW_AW-1:0] ld_row,
   input  logic [BIT_AW-1:0] ld_victim,
   input  logic [BIT_AW-1:0] ld_dist_lo,
   input  logic [BIT_AW-1:0] ld_dist_hi,
   output logic              ent_valid  [N_ENT],
   output logic [ROW_AW-1:0] ent_row    [N_ENT],
   output logic [BIT_AW-1:0] ent_victim [N_ENT],
   output logic [BIT_AW-1:0] ent_dlo    [N_ENT],
   output logic [BIT_AW-1:0] ent_dhi    [N_ENT]
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < N_ENT; e++) begin
            ent_valid[e]  <= 1'b0;
            ent_row[e]    <= '0;
            ent_victim[e] <= '0;
            ent_dlo[e]    <= '0;
            ent_dhi[e]    <= '0;
         end
      end else if (ld_en) begin
         ent_valid[ld_idx]  <= ld_valid;
         ent_row[ld_idx]    <= ld_row;
         ent_victim[ld_idx] <= ld_victim;
         ent_dlo[ld_idx]    <= ld_dist_lo;
         ent_dhi[ld_idx]    <= ld_dist_hi;
      end
   end
endmodule

// File: rtl/crs_pattern_match.sv
module crs_pattern_match #(
   parameter int ROW_W = 32,
   localparam int BIT_AW = $clog2(ROW_W)
) (
   input  logic [ROW_W-1:0]  data,
   input  logic [BIT_AW-1:0] victim,
   input  logic [BIT_AW-1:0] dlo,
   input  logic [BIT_AW-1:0] dhi,
   output logic              hit
);
   logic              lo_ok;
   logic              hi_ok;
   logic [BIT_AW-1:0] lo_pos;
   logic [BIT_AW:0]   hi_sum;

   always_comb begin
      lo_ok  = (victim >= dlo);
      lo_pos = victim - dlo;
      hi_sum = {1'b0, victim} + {1'b0, dhi};
      hi_ok  = (hi_sum < (BIT_AW + 1)'(ROW_W));
      hit    = data[victim]
             & (~lo_ok | ~data[lo_pos])
             & (~hi_ok | ~data[hi_sum[BIT_AW-1:0]]);
   end
endmodule

// File: rtl/crs_row_state.sv
module crs_row_state #(
   parameter int N_ROWS = 16,
   localparam int ROW_AW = $clog2(N_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ROW_AW-1:0] wr_row,
   input  logic              wr_hit,
   input  logic              clr_a_en,
   input  logic [ROW_AW-1:0] clr_a_row,
   input  logic              clr_b_en,
   input  logic [ROW_AW-1:0] clr_b_row,
   output logic [N_ROWS-1:0] row_known,
   output logic [N_ROWS-1:0] row_hit
);
   // Later assignments win: table-load clears override a same-cycle write.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_known <= '0;
         row_hit   <= '0;
      end else begin
         if (wr_en) begin
            row_known[wr_row] <= 1'b1;
            row_hit[wr_row]   <= wr_hit;
         end
         if (clr_b_en) begin
            row_known[clr_b_row] <= 1'b0;
            row_hit[clr_b_row]   <= 1'b0;
         end
         if (clr_a_en) begin
            row_known[clr_a_row] <= 1'b0;
            row_hit[clr_a_row]   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/content_refresh_sel.sv
module content_refresh_sel
   import crs_pkg::*;
#(
   parameter int N_ROWS = 16,
   parameter int ROW_W  = 32,
   parameter int N_ENT  = 4,
   localparam int ROW_AW = $clog2(N_ROWS),
   localparam int BIT_AW = $clog2(ROW_W),
   localparam int ENT_AW = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_mode,
   input  logic              ld_en,
   input  logic [ENT_AW-1:0] ld_idx,
   input  logic              ld_valid,
   input  logic [ROW_AW-1:0] ld_row,
   input  logic [BIT_AW-1:0] ld_victim,
   input  logic [BIT_AW-1:0] ld_dist_lo,
   input  logic [BIT_AW-1:0] ld_dist_hi,
   input  logic              wr_en,
   input  logic [ROW_AW-1:0] wr_row,
   input  logic [ROW_W-1:0]  wr_data,
   input  logic              ref_req,
   input  logic [ROW_AW-1:0] ref_row,
   output logic              ref_valid,
   output logic              ref_high
);
   initial begin
      assert (is_pow2(N_ROWS)) else $fatal(1, "N_ROWS must be a power of two");
      assert (is_pow2(ROW_W))  else $fatal(1, "ROW_W must be a power of two");
      assert (is_pow2(N_ENT))  else $fatal(1, "N_ENT must be a power of two");
   end

   logic              ent_valid  [N_ENT];
   logic [ROW_AW-1:0] ent_row    [N_ENT];
   logic [BIT_AW-1:0] ent_victim [N_ENT];
   logic [BIT_AW-1:0] ent_dlo    [N_ENT];
   logic [BIT_AW-1:0] ent_dhi    [N_ENT];
   logic [N_ENT-1:0]  ent_hit;
   logic [N_ENT-1:0]  wr_sel;
   logic [N_ENT-1:0]  ref_sel;
   logic [N_ROWS-1:0] row_known;
   logic [N_ROWS-1:0] row_hit;
   logic              wr_hit;
   logic              req_has_entry;
   logic              old_en;
   rate_e             rate_next;

   crs_entry_table #(.N_ROWS(N_ROWS), .ROW_W(ROW_W), .N_ENT(N_ENT)) u_table (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
      .ld_valid(ld_valid), .ld_row(ld_row), .ld_victim(ld_victim),
      .ld_dist_lo(ld_dist_lo), .ld_dist_hi(ld_dist_hi),
      .ent_valid(ent_valid), .ent_row(ent_row), .ent_victim(ent_victim),
      .ent_dlo(ent_dlo), .ent_dhi(ent_dhi)
   );

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      crs_pattern_match #(.ROW_W(ROW_W)) u_match (
         .data(wr_data), .victim(ent_victim[e]),
         .dlo(ent_dlo[e]), .dhi(ent_dhi[e]), .hit(ent_hit[e])
      );
      assign wr_sel[e]  = ent_valid[e] && (ent_row[e] == wr_row) && ent_hit[e];
      assign ref_sel[e] = ent_valid[e] && (ent_row[e] == ref_row);
   end

   assign wr_hit        = |wr_sel;
   assign req_has_entry = |ref_sel;
   assign old_en        = ld_en && ent_valid[ld_idx];

   crs_row_state #(.N_ROWS(N_ROWS)) u_state (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_row(wr_row), .wr_hit(wr_hit),
      .clr_a_en(ld_en), .clr_a_row(ld_row),
      .clr_b_en(old_en), .clr_b_row(ent_row[ld_idx]),
      .row_known(row_known), .row_hit(row_hit)
   );

   always_comb begin
      rate_next = RATE_LOW;
      if (req_has_entry && (base_mode || !row_known[ref_row] || row_hit[ref_row]))
         rate_next = RATE_HIGH;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_valid <= 1'b0;
         ref_high  <= 1'b0;
      end else begin
         ref_valid <= ref_req;
         ref_high  <= ref_req && (rate_next == RATE_HIGH);
      end
   end
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
   parameter int N_ROWS = 16,
   localparam int ROW_AW = $clog2(N_ROWS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              base_mode,
   input logic              ref_req,
   input logic              ref_valid,
   input logic              ref_high,
   input logic              req_has_entry,
   input logic              ld_en,
   input logic [ROW_AW-1:0] ld_row,
   input logic              wr_en,
   input logic [ROW_AW-1:0] wr_row,
   input logic [N_ROWS-1:0] row_known
);
   AST_NO_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req && !req_has_entry |=> !ref_high); // R1
   AST_BASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req && base_mode && req_has_entry |=> ref_high); // R5
   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |=> ref_valid); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_req |=> !ref_valid && !ref_high); // R8
   AST_LOAD_UNSEEN: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> !row_known[$past(ld_row)]); // R6
   AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !ld_en |=> row_known[$past(wr_row)]); // R2
endmodule

bind content_refresh_sel crs_checker #(.N_ROWS(N_ROWS)) u_chk (
   .clk(clk), .rst_n(rst_n), .base_mode(base_mode), .ref_req(ref_req),
   .ref_valid(ref_valid), .ref_high(ref_high), .req_has_entry(req_has_entry),
   .ld_en(ld_en), .ld_row(ld_row), .wr_en(wr_en), .wr_row(wr_row),
   .row_known(row_known)
);

// File: tb/content_refresh_sel_test.sv
module content_refresh_sel_test;
   localparam int NR = 16;
   localparam int RW = 32;
   localparam int NE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_mode = 1'b0;
   logic        ld_en = 1'b0;
   logic [1:0]  ld_idx = '0;
   logic        ld_valid = 1'b0;
   logic [3:0]  ld_row = '0;
   logic [4:0]  ld_victim = '0;
   logic [4:0]  ld_dist_lo = '0;
   logic [4:0]  ld_dist_hi = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_row = '0;
   logic [31:0] wr_data = '0;
   logic        ref_req = 1'b0;
   logic [3:0]  ref_row = '0;
   logic        ref_valid;
   logic        ref_high;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   bit m_valid [NE];
   int m_row [NE], m_vic [NE], m_dlo [NE], m_dhi [NE];
   bit m_known [NR], m_hit [NR];

   always #10 clk = ~clk;

   content_refresh_sel #(.N_ROWS(NR), .ROW_W(RW), .N_ENT(NE)) uut (
      .clk(clk), .rst_n(rst_n), .base_mode(base_mode), .ld_en(ld_en),
      .ld_idx(ld_idx), .ld_valid(ld_valid), .ld_row(ld_row),
      .ld_victim(ld_victim), .ld_dist_lo(ld_dist_lo), .ld_dist_hi(ld_dist_hi),
      .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
      .ref_req(ref_req), .ref_row(ref_row),
      .ref_valid(ref_valid), .ref_high(ref_high)
   );

   function automatic bit pat(logic [31:0] d, int v, int dl, int dh);
      bit ok = (d[v] == 1'b1);
      if (v - dl >= 0 && d[v - dl]) ok = 0;
      if (v + dh < RW && d[v + dh]) ok = 0;
      return ok;
   endfunction

   function automatic bit has_entry(int r);
      for (int e = 0; e < NE; e++) if (m_valid[e] && m_row[e] == r) return 1;
      return 0;
   endfunction

   function automatic bit row_match(int r, logic [31:0] d);
      for (int e = 0; e < NE; e++)
         if (m_valid[e] && m_row[e] == r && pat(d, m_vic[e], m_dlo[e], m_dhi[e])) return 1;
      return 0;
   endfunction

   task automatic check(bit got_v, bit got_h, bit exp_v, bit exp_h, string tag);
      checks++;
      if (got_v !== exp_v || got_h !== exp_h) begin
         fails++;
         $display("FAIL %s: valid/high = %0b/%0b, expected %0b/%0b", tag, got_v, got_h, exp_v, exp_h);
      end
   endtask

   // Called on a falling edge; drives one cycle, checks the answer one edge later.
   task automatic step(bit le, int li, bit lv, int lr, int lvic, int ldl, int ldh,
                       bit we, int wrr, logic [31:0] wd, bit rq, int rr, string tag);
      bit exp_h, whit;
      ld_en = le; ld_idx = 2'(li); ld_valid = lv; ld_row = 4'(lr);
      ld_victim = 5'(lvic); ld_dist_lo = 5'(ldl); ld_dist_hi = 5'(ldh);
      wr_en = we; wr_row = 4'(wrr); wr_data = wd;
      ref_req = rq; ref_row = 4'(rr);
      exp_h = rq && has_entry(rr) && (base_mode || !m_known[rr] || m_hit[rr]);
      whit = row_match(wrr, wd);
      @(negedge clk);
      check(ref_valid, ref_high, rq, exp_h, tag);
      if (we) begin m_known[wrr] = 1; m_hit[wrr] = whit; end
      if (le) begin
         if (m_valid[li]) begin m_known[m_row[li]] = 0; m_hit[m_row[li]] = 0; end
         m_known[lr] = 0; m_hit[lr] = 0;
         m_valid[li] = lv; m_row[li] = lr; m_vic[li] = lvic; m_dlo[li] = ldl; m_dhi[li] = ldh;
      end
      ld_en = 0; wr_en = 0; ref_req = 0;
   endtask

   task automatic ld(int i, int r, int v, int dl, int dh);
      step(1, i, 1, r, v, dl, dh, 0, 0, '0, 0, 0, "R6");
   endtask
   task automatic wr(int r, logic [31:0] d);
      step(0, 0, 0, 0, 0, 0, 0, 1, r, d, 0, 0, "R8");
   endtask
   task automatic rf(int r, string tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, '0, 1, r, tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, '0, 0, 0, "R8");
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int e = 0; e < NE; e++) m_valid[e] = 0;
      for (int r = 0; r < NR; r++) begin m_known[r] = 0; m_hit[r] = 0; end
      repeat (3) @(negedge clk);
      check(ref_valid, ref_high, 0, 0, "R9");
      rst_n = 1'b1;
      @(negedge clk);
      rf(5, "R9");                          // empty table: low
      ld(0, 3, 10, 1, 5);
      rf(3, "R6");                          // loaded, unseen content: high
      rf(4, "R1");
      wr(3, 32'h0000_0400); rf(3, "R2");    // 0-1-0 at bits 9/10/15: high
      wr(3, 32'h0000_0600); rf(3, "R2");    // lower neighbour 1: low
      wr(3, 32'h0000_8400); rf(3, "R2");    // upper neighbour 1: low
      wr(3, 32'h0000_0000); rf(3, "R2");    // victim 0: low
      base_mode = 1'b1;
      rf(3, "R5"); rf(4, "R5");
      base_mode = 1'b0;
      wr(4, 32'hFFFF_FFFF); rf(4, "R1");
      ld(1, 5, 0, 1, 3);  wr(5, 32'h0000_0001); rf(5, "R3");
      ld(2, 6, 31, 2, 4); wr(6, 32'h8000_0000); rf(6, "R3");
      ld(3, 3, 20, 1, 1);
      wr(3, 32'h0010_0600); rf(3, "R4");    // only second entry matches: high
      wr(3, 32'h0030_0000); rf(3, "R4");    // neither matches: low
      step(1, 3, 1, 3, 20, 1, 1, 1, 3, 32'h0, 0, 0, "R7");
      rf(3, "R7");                          // load won: high
      ld(1, 7, 2, 1, 1); rf(5, "R6");       // entry moved away: row 5 low
      wr(7, 32'h4); rf(7, "R2");
      for (int i = 0; i < 600; i++) begin
         bit le = ($urandom % 10) == 0;
         bit we = ($urandom % 3) == 0;
         logic [31:0] d = $urandom & $urandom & $urandom;
         if (($urandom % 8) == 0) base_mode = ~base_mode;
         step(le, $urandom % NE, ($urandom % 5) != 0, $urandom % NR, $urandom % RW,
              $urandom % 6, $urandom % 6, we, $urandom % NR, d,
              ($urandom % 2) == 0, $urandom % NR, "R2");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule